// File: doc/BRIEF.md
# Power-Up Configuration Byte Loader

This block runs once after reset. It reads a single configuration byte from an external non-volatile store, decodes four settings from it, and then holds those settings fixed until the next reset. When the store is absent, fixed defaults are applied instead and no read is issued. The read uses a simple handshake. The block raises a request with a fixed byte address and keeps both steady until the store returns a valid strobe with the data.

The decoded settings say four things. The first is which side of the device owns the bus-master address and transfer-count registers. The next two say whether the read-side and write-side strobes act as clock-synchronous enables or as asynchronous data clocks. The last says whether the target latency timeout is active. The block also sits in the write path of those bus-master registers. Writes from the owning side pass through, one cycle late. Writes from the other side are dropped and reported with a one-cycle error pulse. No write is honoured until the configuration has been latched.

Top module: `cfg_byte_loader`

## Requirements
- R1: With the store present, from the first cycle after reset the request output is high and the address output reads 0x45. Both stay that way until a cycle in which the valid input is high.
- R2: A fetched byte is decoded as follows. Bit 7 = 1 gives PCI-side ownership and 0 gives local-side ownership. Bit 6 = 1 makes the read strobes asynchronous and 0 makes them synchronous. Bit 5 does the same for the write strobes. Bit 0 = 1 enables the latency timeout.
- R3: With the store absent at the first cycle after reset, no request is issued. Ready rises one cycle after reset with PCI ownership, both strobe modes asynchronous and the latency timeout enabled.
- R4: Ready rises the cycle after the valid byte is accepted and stays high. After that, the request is low and further valid strobes or data leave every decoded output unchanged.
- R5: While ready is low, writes from either side produce neither a register write nor an error pulse.
- R6: Once ready is high, a write from the owning side appears on the register write port one cycle later, carrying that side's data.
- R7: Once ready is high, a write from the non-owning side is dropped and raises the error output for exactly one cycle, one cycle later. This holds even when the owner writes in the same cycle.
- R8: During reset the request, ready, register write and error outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nvm_present_i | input | 1 | High when the non-volatile store is fitted |
| nvm_req_o | output | 1 | Read request to the store |
| nvm_addr_o | output | 8 | Byte address of the read |
| nvm_valid_i | input | 1 | Store returns the byte in this cycle |
| nvm_data_i | input | 8 | Returned byte |
| cfg_ready_o | output | 1 | Configuration latched |
| bm_owner_pci_o | output | 1 | 1: PCI side owns bus-master registers, 0: local side |
| rd_async_o | output | 1 | 1: read strobes are asynchronous clocks |
| wr_async_o | output | 1 | 1: write strobes are asynchronous clocks |
| lat_timer_en_o | output | 1 | Target latency timeout enabled |
| pci_wr_i | input | 1 | PCI-side write to bus-master registers |
| pci_wdata_i | input | 32 | PCI-side write data |
| loc_wr_i | input | 1 | Local-side write to bus-master registers |
| loc_wdata_i | input | 32 | Local-side write data |
| bm_wr_o | output | 1 | Filtered register write |
| bm_wdata_o | output | 32 | Filtered write data |
| bm_wr_err_o | output | 1 | Non-owner write dropped |

## Verification
The assertions assume that the presence input is steady across the first cycle after reset and that the store returns data only while a request is pending. The bench holds presence fixed for each reset episode. It answers each request with a single valid cycle after a random delay. Stray valid strobes are injected only after ready, where R4 requires them to be ignored. Write strobes from both sides are random and may coincide in the same cycle, before and after ready.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
    localparam int OWNER_BIT = 7;
    localparam int RD_BIT    = 6;
    localparam int WR_BIT    = 5;
    localparam int LAT_BIT   = 0;

    typedef enum logic [1:0] {
        LD_START = 2'd0,
        LD_FETCH = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic owner_pci;
        logic rd_async;
        logic wr_async;
        logic lat_en;
    } cfg_fields_t;

    function automatic cfg_fields_t decode_cfg(input logic [7:0] b);
        cfg_fields_t f;
        f.owner_pci = b[OWNER_BIT];
        f.rd_async  = b[RD_BIT];
        f.wr_async  = b[WR_BIT];
        f.lat_en    = b[LAT_BIT];
        return f;
    endfunction
endpackage

// File: rtl/cfg_fetch_fsm.sv
module cfg_fetch_fsm
    import cfg_ldr_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter logic [7:0]  DEFAULT_BYTE = 8'hE1,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              present_i,
    input  logic              valid_i,
    input  logic [7:0]        data_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o,
    output logic [7:0]        byte_o
);
    typedef struct packed {
        ld_state_e  state;
        logic [7:0] cfg;
    } fetch_st_t;

    fetch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            LD_START: st_d.state = present_i ? LD_FETCH : LD_DONE;
            LD_FETCH: begin
                if (valid_i) begin
                    st_d.cfg   = data_i;
                    st_d.state = LD_DONE;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= LD_START;
            st_q.cfg   <= DEFAULT_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = (st_q.state == LD_FETCH);
    assign addr_o  = CFG_ADDR;
    assign ready_o = (st_q.state == LD_DONE);
    assign byte_o  = st_q.cfg;

    // R1
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !valid_i) |=> req_o);

    // R4
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> (ready_o && !req_o && $stable(byte_o)));
endmodule

// File: rtl/cfg_wr_filter.sv
module cfg_wr_filter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic              owner_pci_i,
    input  logic              pci_wr_i,
    input  logic [DATA_W-1:0] pci_wdata_i,
    input  logic              loc_wr_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              err_o
);
    typedef struct packed {
        logic              wr;
        logic              err;
        logic [DATA_W-1:0] data;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic own_wr, foreign_wr;

    always_comb begin
        own_wr     = owner_pci_i ? pci_wr_i : loc_wr_i;
        foreign_wr = owner_pci_i ? loc_wr_i : pci_wr_i;
        st_d       = st_q;
        st_d.wr    = ready_i && own_wr;
        st_d.err   = ready_i && foreign_wr;
        if (ready_i && own_wr)
            st_d.data = owner_pci_i ? pci_wdata_i : loc_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_o    = st_q.wr;
    assign err_o   = st_q.err;
    assign wdata_o = st_q.data;

    // R5
    pre_ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> (!wr_o && !err_o));

    // R7
    foreign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && (owner_pci_i ? loc_wr_i : pci_wr_i)) |=> err_o);

    // R6
    owner_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && owner_pci_i && pci_wr_i) |=> (wr_o && wdata_o == $past(pci_wdata_i)));
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
    import cfg_ldr_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         DATA_W       = 32,
    parameter logic [7:0] DEFAULT_BYTE = 8'hE1,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nvm_present_i,
    output logic              nvm_req_o,
    output logic [ADDR_W-1:0] nvm_addr_o,
    input  logic              nvm_valid_i,
    input  logic [7:0]        nvm_data_i,
    output logic              cfg_ready_o,
    output logic              bm_owner_pci_o,
    output logic              rd_async_o,
    output logic              wr_async_o,
    output logic              lat_timer_en_o,
    input  logic              pci_wr_i,
    input  logic [DATA_W-1:0] pci_wdata_i,
    input  logic              loc_wr_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    output logic              bm_wr_o,
    output logic [DATA_W-1:0] bm_wdata_o,
    output logic              bm_wr_err_o
);
    logic [7:0]  cfg_byte;
    cfg_fields_t fields;

    cfg_fetch_fsm #(
        .ADDR_W(ADDR_W), .DEFAULT_BYTE(DEFAULT_BYTE), .CFG_ADDR(CFG_ADDR)
    ) fetch_i (
        .clk(clk), .rst_n(rst_n), .present_i(nvm_present_i),
        .valid_i(nvm_valid_i), .data_i(nvm_data_i),
        .req_o(nvm_req_o), .addr_o(nvm_addr_o),
        .ready_o(cfg_ready_o), .byte_o(cfg_byte)
    );

    assign fields         = decode_cfg(cfg_byte);
    assign bm_owner_pci_o = fields.owner_pci;
    assign rd_async_o     = fields.rd_async;
    assign wr_async_o     = fields.wr_async;
    assign lat_timer_en_o = fields.lat_en;

    cfg_wr_filter #(.DATA_W(DATA_W)) filt_i (
        .clk(clk), .rst_n(rst_n), .ready_i(cfg_ready_o),
        .owner_pci_i(fields.owner_pci),
        .pci_wr_i(pci_wr_i), .pci_wdata_i(pci_wdata_i),
        .loc_wr_i(loc_wr_i), .loc_wdata_i(loc_wdata_i),
        .wr_o(bm_wr_o), .wdata_o(bm_wdata_o), .err_o(bm_wr_err_o)
    );
endmodule

// File: tb/cfg_byte_loader_tb.sv
module cfg_byte_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        nvm_present_i, nvm_valid_i;
    logic [7:0]  nvm_data_i;
    logic        nvm_req_o, cfg_ready_o;
    logic [7:0]  nvm_addr_o;
    logic        bm_owner_pci_o, rd_async_o, wr_async_o, lat_timer_en_o;
    logic        pci_wr_i, loc_wr_i, bm_wr_o, bm_wr_err_o;
    logic [31:0] pci_wdata_i, loc_wdata_i, bm_wdata_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] exp_byte;
    bit         exp_ready;

    always #2 clk = ~clk;

    cfg_byte_loader dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [3:0] fields_of(input logic [7:0] b);
        return {b[7], b[6], b[5], b[0]};
    endfunction

    task automatic check_fields(input string req);
        logic [3:0] act = {bm_owner_pci_o, rd_async_o, wr_async_o, lat_timer_en_o};
        check(act == fields_of(exp_byte), req, "fields", act, fields_of(exp_byte));
    endtask

    // one cycle: drive at negedge, check filter outputs at the next negedge
    task automatic step(input bit vld, input logic [7:0] d, input bit force_both);
        bit pw, lw, ewr, eerr, own;
        logic [31:0] pd, ld, edata;
        pw = force_both || ($urandom % 3 == 0);
        lw = force_both || ($urandom % 3 == 0);
        pd = $urandom; ld = $urandom;
        pci_wr_i = pw; loc_wr_i = lw; pci_wdata_i = pd; loc_wdata_i = ld;
        nvm_valid_i = vld; nvm_data_i = d;
        own   = exp_byte[7];
        ewr   = exp_ready && (own ? pw : lw);
        eerr  = exp_ready && (own ? lw : pw);
        edata = own ? pd : ld;
        @(negedge clk);
        nvm_valid_i = 1'b0;
        if (exp_ready) begin
            check(bm_wr_o == ewr, "R6", "bm_wr", bm_wr_o, ewr);
            if (ewr) check(bm_wdata_o == edata, "R6", "bm_wdata", bm_wdata_o, edata);
            check(bm_wr_err_o == eerr, "R7", "err", bm_wr_err_o, eerr);
        end else begin
            check(!bm_wr_o && !bm_wr_err_o, "R5", "pre-ready write",
                  {bm_wr_o, bm_wr_err_o}, 0);
        end
    endtask

    task automatic do_reset(input bit present);
        rst_n = 1'b0; nvm_present_i = present; nvm_valid_i = 1'b0; nvm_data_i = '0;
        pci_wr_i = 1'b0; loc_wr_i = 1'b0; pci_wdata_i = '0; loc_wdata_i = '0;
        exp_ready = 1'b0; exp_byte = 8'hE1;
        repeat (3) @(negedge clk);
        check(!nvm_req_o && !cfg_ready_o && !bm_wr_o && !bm_wr_err_o, "R8", "reset outs",
              {nvm_req_o, cfg_ready_o, bm_wr_o, bm_wr_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_mem(input logic [7:0] b, input int lat, input int nwr);
        do_reset(1'b1);
        for (int i = 0; i < lat; i++) begin
            check(nvm_req_o && nvm_addr_o == 8'h45, "R1", "req/addr",
                  {nvm_req_o, nvm_addr_o}, {1'b1, 8'h45});
            check(!cfg_ready_o, "R4", "ready early", cfg_ready_o, 0);
            step(1'b0, 8'h00, i == 0);
        end
        check(nvm_req_o && nvm_addr_o == 8'h45, "R1", "req at accept",
              {nvm_req_o, nvm_addr_o}, {1'b1, 8'h45});
        step(1'b1, b, 1'b1);
        exp_byte = b; exp_ready = 1'b1;
        check(cfg_ready_o && !nvm_req_o, "R4", "ready/req", {cfg_ready_o, nvm_req_o}, 2'b10);
        check_fields("R2");
        step(1'b1, ~b, 1'b1);
        check_fields("R4");
        check(cfg_ready_o, "R4", "ready held", cfg_ready_o, 1);
        for (int i = 0; i < nwr; i++) step(($urandom % 5) == 0, 8'($urandom), (i % 7) == 0);
        check_fields("R4");
    endtask

    task automatic run_nomem(input int nwr);
        do_reset(1'b0);
        exp_ready = 1'b1; exp_byte = 8'hE1;
        check(cfg_ready_o && !nvm_req_o, "R3", "ready/no req", {cfg_ready_o, nvm_req_o}, 2'b10);
        check({bm_owner_pci_o, rd_async_o, wr_async_o, lat_timer_en_o} == 4'hF, "R3",
              "defaults", {bm_owner_pci_o, rd_async_o, wr_async_o, lat_timer_en_o}, 4'hF);
        for (int i = 0; i < nwr; i++) step(1'b0, 8'h00, (i % 5) == 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        run_nomem(20);
        run_mem(8'h00, 0, 20);
        run_mem(8'hFF, 3, 20);
        run_mem(8'h7E, 1, 20);
        run_mem(8'h81, 5, 20);
        for (int k = 0; k < 12; k++) run_mem(8'($urandom), $urandom % 6, 30);
        run_nomem(10);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule